// File: doc/BRIEF.md
# DDR2 Termination Pin Sequencer

This block sits on the controller side of one DDR2 rank. It drives the on-die termination request pin and keeps a cycle-level model of whether the memory's internal termination is active. The write path announces each burst by giving the number of cycles until the first data beat and the number of beat cycles. The sequencer raises the pin early enough that termination has settled by the first beat. It lowers the pin at a point where termination stays on past the last beat.

The model follows the device's delays in whole clock cycles. Termination switches on a fixed number of cycles after the pin is sampled high. It switches off a longer fixed number of cycles after the pin is sampled low, because the half-cycle turn-off delay is rounded up. The termination strength comes from a two-bit field of the first extended mode register, taken from address bits 6 and 2. A strength change takes effect a set number of cycles after the mode-register command. When the field selects "disabled", the memory ignores the pin and termination stays off.

The sequencer also checks requests against clock-enable power-down. A request is refused if the pin would be used too soon after power-down exit, or if it arrives while powered down. A power-down entry is flagged when the pin changed too recently or a burst is still scheduled.

Top module: `ddr2_odt_seq`

## Requirements
- R1: A mode-register write with bank field 1 loads the strength code {addr[6], addr[2]}. Code 00 reads as 0 ohm (off), 01 as 75, 10 as 150 and 11 as 50 on `rtt_ohms`; `rtt_code` shows the code itself.
- R2: A strength update appears on `rtt_code` exactly MOD_CYC cycles after the edge that samples the write. A write whose bank field is not 1 changes nothing.
- R3: While the strength code is 00, `term_on` stays low whatever `odt` does.
- R4: A request accepted at edge k with lead L and length N makes `odt` high after edges k+L-AOND through k+L-AOND+N-1, and low otherwise.
- R5: `term_on` rises AOND cycles after `odt` rises, so termination is on from the first beat at edge k+L.
- R6: `term_on` falls AOFD cycles after `odt` falls, which keeps it on through edge k+L+N (one cycle past the last beat).
- R7: A request is refused when L < AOND, when N = 0, or while an earlier burst is still scheduled. A refused request gives a one-cycle `sched_err` and leaves `odt` untouched.
- R8: A request is refused when `cke` is low at its edge. It is also refused when the `odt` rise would come fewer than AXPD cycles after the power-down exit edge (the first edge with `cke` high).
- R9: A `cke` fall gives a one-cycle `pd_err` if `odt` last changed fewer than ANPD edges before the entry edge, or if a burst is still scheduled.
- R10: After reset `odt`, `term_on`, `sched_err` and `pd_err` are low and the strength code is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable as driven to the rank; low means power-down |
| req_valid | input | 1 | Write-burst termination request |
| req_lead | input | LEAD_W | Cycles from the request edge to the first data beat |
| req_len | input | LEN_W | Number of data beat cycles |
| mrs_wr | input | 1 | Mode-register command issued this cycle |
| mrs_ba | input | 2 | Bank field of the mode-register command |
| mrs_addr | input | AW | Address operand of the mode-register command |
| odt | output | 1 | Termination request pin |
| term_on | output | 1 | Modelled state of the device's internal termination |
| rtt_code | output | 2 | Active strength code |
| rtt_ohms | output | 8 | Active termination value in ohms (0 when off) |
| sched_err | output | 1 | One-cycle pulse: request refused |
| pd_err | output | 1 | One-cycle pulse: power-down entered against the pin rules |

## Verification
The termination delay checks assume the strength code stays the same across the cycles they compare. They only look at edges where `rtt_code` is stable, so a strength change cannot be mistaken for a timing fault. The error-cause checks assume `cke` is held high through reset, which the stimulus does. The stimulus changes the strength only while no burst is in flight. It drops `cke` only at chosen distances from a pin change, and it waits out the exit window before the next normal request.

// File: rtl/ddr2_odt_pkg.sv
package ddr2_odt_pkg;
   typedef logic [1:0] rtt_t;

   localparam rtt_t RTT_OFF = 2'b00;
   localparam rtt_t RTT_75  = 2'b01;
   localparam rtt_t RTT_150 = 2'b10;
   localparam rtt_t RTT_50  = 2'b11;

   function automatic logic [7:0] rtt_to_ohms(input rtt_t code);
      case (code)
         RTT_75:  return 8'd75;
         RTT_150: return 8'd150;
         RTT_50:  return 8'd50;
         default: return 8'd0;
      endcase
   endfunction
endpackage

// File: rtl/odt_sched.sv
module odt_sched #(
   parameter int AOND   = 2,
   parameter int LEAD_W = 6,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_go,
   input  logic [LEAD_W-1:0] req_lead,
   input  logic [LEN_W-1:0]  req_len,
   output logic              busy,
   output logic              odt,
   output logic              odt_nxt
);
   localparam logic [LEAD_W-1:0] LEAD_AT_ONCE = LEAD_W'(AOND);

   logic [LEAD_W-1:0] wait_cnt;
   logic [LEN_W-1:0]  hold_cnt, len_q, hold_nxt;
   logic              fire, fire_now;

   always_comb begin
      fire_now = req_go && (req_lead == LEAD_AT_ONCE);
      fire     = fire_now || (wait_cnt == LEAD_W'(1));
      if (fire)
         hold_nxt = fire_now ? req_len : len_q;
      else if (hold_cnt != '0)
         hold_nxt = hold_cnt - LEN_W'(1);
      else
         hold_nxt = '0;
      if (fire)
         odt_nxt = 1'b1;
      else if (hold_cnt == LEN_W'(1))
         odt_nxt = 1'b0;
      else
         odt_nxt = odt;
   end

   assign busy = (wait_cnt != '0) || (hold_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_cnt <= '0;
         hold_cnt <= '0;
         len_q    <= '0;
         odt      <= 1'b0;
      end else begin
         if (req_go && !fire_now)
            wait_cnt <= req_lead - LEAD_AT_ONCE;
         else if (wait_cnt != '0)
            wait_cnt <= wait_cnt - LEAD_W'(1);
         if (req_go)
            len_q <= req_len;
         hold_cnt <= hold_nxt;
         odt      <= odt_nxt;
      end
   end
endmodule

// File: rtl/odt_guard.sv
module odt_guard #(
   parameter int AOND   = 2,
   parameter int ANPD   = 3,
   parameter int AXPD   = 8,
   parameter int LEAD_W = 6,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              req_valid,
   input  logic [LEAD_W-1:0] req_lead,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              busy,
   input  logic              odt,
   input  logic              odt_nxt,
   output logic              req_go,
   output logic              sched_err,
   output logic              pd_err
);
   localparam int QW = $clog2(ANPD + 1);
   localparam int XW = $clog2(AXPD + 1);

   logic [QW-1:0] quiet;
   logic [XW-1:0] since_up;
   logic          cke_q, refuse, too_soon;
   int            slack;

   always_comb begin
      slack    = int'(req_lead) - AOND;
      too_soon = (slack + int'(since_up)) < AXPD;
      refuse   = !cke || busy || (slack < 0) || (req_len == '0) || too_soon;
      req_go   = req_valid && !refuse;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet     <= QW'(ANPD);
         since_up  <= XW'(AXPD);
         cke_q     <= 1'b1;
         sched_err <= 1'b0;
         pd_err    <= 1'b0;
      end else begin
         sched_err <= req_valid && refuse;
         pd_err    <= !cke && cke_q && (busy || (int'(quiet) < ANPD - 1));
         cke_q     <= cke;
         if (odt_nxt != odt)
            quiet <= '0;
         else if (int'(quiet) < ANPD)
            quiet <= quiet + QW'(1);
         if (!cke)
            since_up <= '0;
         else if (int'(since_up) < AXPD)
            since_up <= since_up + XW'(1);
      end
   end
endmodule

// File: rtl/odt_term_model.sv
module odt_term_model
   import ddr2_odt_pkg::*;
#(
   parameter int AOND    = 2,
   parameter int AOFD    = 3,
   parameter int MOD_CYC = 4,
   parameter int AW      = 14,
   parameter int EMR_BA  = 1,
   parameter int HI_BIT  = 6,
   parameter int LO_BIT  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          odt,
   input  logic          mrs_wr,
   input  logic [1:0]    mrs_ba,
   input  logic [AW-1:0] mrs_addr,
   output logic          term_on,
   output rtt_t          rtt_code,
   output logic [7:0]    rtt_ohms
);
   logic [AOFD-1:0] hist;
   logic            emr_hit, odt_seen;
   rtt_t            rtt_in;

   assign emr_hit = mrs_wr && (mrs_ba == 2'(EMR_BA));
   assign rtt_in  = {mrs_addr[HI_BIT], mrs_addr[LO_BIT]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= '0;
      else        hist <= {hist[AOFD-2:0], odt};
   end

   always_comb begin
      odt_seen = 1'b0;
      for (int i = AOND - 1; i < AOFD; i++)
         odt_seen = odt_seen | hist[i];
   end

   generate
      if (MOD_CYC == 0) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       rtt_code <= RTT_OFF;
            else if (emr_hit) rtt_code <= rtt_in;
         end
      end else begin : g_delayed
         localparam int CW = $clog2(MOD_CYC + 1);
         logic [CW-1:0] cnt;
         rtt_t          pend;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt      <= '0;
               pend     <= RTT_OFF;
               rtt_code <= RTT_OFF;
            end else if (emr_hit) begin
               cnt  <= CW'(MOD_CYC);
               pend <= rtt_in;
            end else if (cnt != '0) begin
               cnt <= cnt - CW'(1);
               if (cnt == CW'(1)) rtt_code <= pend;
            end
         end
      end
   endgenerate

   assign term_on  = (rtt_code != RTT_OFF) && odt_seen;
   assign rtt_ohms = rtt_to_ohms(rtt_code);
endmodule

// File: rtl/ddr2_odt_seq.sv
module ddr2_odt_seq
   import ddr2_odt_pkg::*;
#(
   parameter int AOND    = 2,
   parameter int AOFD    = 3,
   parameter int ANPD    = 3,
   parameter int AXPD    = 8,
   parameter int MOD_CYC = 4,
   parameter int LEAD_W  = 6,
   parameter int LEN_W   = 4,
   parameter int AW      = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              req_valid,
   input  logic [LEAD_W-1:0] req_lead,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              mrs_wr,
   input  logic [1:0]        mrs_ba,
   input  logic [AW-1:0]     mrs_addr,
   output logic              odt,
   output logic              term_on,
   output logic [1:0]        rtt_code,
   output logic [7:0]        rtt_ohms,
   output logic              sched_err,
   output logic              pd_err
);
   generate
      if (AOND < 1)        begin : g_bad_on   $error("AOND must be at least 1");        end
      if (AOFD < AOND + 1) begin : g_bad_off  $error("AOFD must exceed AOND");          end
      if (MOD_CYC < 0)     begin : g_bad_mod  $error("MOD_CYC must not be negative");   end
      if (AW < 7)          begin : g_bad_aw   $error("AW must cover address bit 6");    end
      if (ANPD < 1 || AXPD < 1) begin : g_bad_pd $error("power-down windows must be positive"); end
   endgenerate

   logic busy, odt_nxt, req_go;
   rtt_t rtt_i;

   odt_guard #(.AOND(AOND), .ANPD(ANPD), .AXPD(AXPD), .LEAD_W(LEAD_W), .LEN_W(LEN_W)) u_guard (
      .clk(clk), .rst_n(rst_n), .cke(cke), .req_valid(req_valid), .req_lead(req_lead),
      .req_len(req_len), .busy(busy), .odt(odt), .odt_nxt(odt_nxt), .req_go(req_go),
      .sched_err(sched_err), .pd_err(pd_err));

   odt_sched #(.AOND(AOND), .LEAD_W(LEAD_W), .LEN_W(LEN_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_lead(req_lead), .req_len(req_len),
      .busy(busy), .odt(odt), .odt_nxt(odt_nxt));

   odt_term_model #(.AOND(AOND), .AOFD(AOFD), .MOD_CYC(MOD_CYC), .AW(AW)) u_term (
      .clk(clk), .rst_n(rst_n), .odt(odt), .mrs_wr(mrs_wr), .mrs_ba(mrs_ba),
      .mrs_addr(mrs_addr), .term_on(term_on), .rtt_code(rtt_i), .rtt_ohms(rtt_ohms));

   assign rtt_code = rtt_i;
endmodule

// File: rtl/ddr2_odt_seq_chk.sv
module ddr2_odt_seq_chk #(
   parameter int AOND = 2,
   parameter int AOFD = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic       req_valid,
   input logic       odt,
   input logic       term_on,
   input logic [1:0] rtt_code,
   input logic       sched_err,
   input logic       pd_err
);
   AST_TERM_ON_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(term_on) && $stable(rtt_code) |-> $past(odt, AOND)); // R5

   AST_TERM_OFF_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(term_on) && $stable(rtt_code) |-> $past(odt, AOFD + 1) && !$past(odt, AOFD)); // R6

   AST_NO_TERM_WITHOUT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(odt, AOND) && !$past(odt, AOFD) && $stable(rtt_code) && (AOFD == AOND + 1) |-> !term_on); // R3

   AST_REFUSAL_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      sched_err |-> $past(req_valid)); // R7

   AST_PD_ERR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      pd_err |-> !$past(cke) && $past(cke, 2)); // R9
endmodule

bind ddr2_odt_seq ddr2_odt_seq_chk #(.AOND(AOND), .AOFD(AOFD)) u_chk (
   .clk(clk), .rst_n(rst_n), .cke(cke), .req_valid(req_valid), .odt(odt),
   .term_on(term_on), .rtt_code(rtt_code), .sched_err(sched_err), .pd_err(pd_err));

// File: tb/ddr2_odt_seq_test.sv
module ddr2_odt_seq_test;
   localparam int PERIOD = 10;
   localparam int AOND = 2, MOD = 4, AXPD = 8;

   logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, req_valid = 1'b0, mrs_wr = 1'b0;
   logic [5:0] req_lead = '0;
   logic [3:0] req_len = '0;
   logic [1:0] mrs_ba = '0;
   logic [13:0] mrs_addr = '0;
   logic odt, term_on, sched_err, pd_err;
   logic [1:0] rtt_code;
   logic [7:0] rtt_ohms;
   int errors = 0, checks = 0;
   bit done = 0;

   // lead, length, accepted
   localparam int VEC [6][3] = '{'{2, 4, 1}, '{5, 1, 1}, '{3, 8, 1}, '{1, 4, 0}, '{4, 0, 0}, '{7, 15, 1}};

   ddr2_odt_seq uut (.clk(clk), .rst_n(rst_n), .cke(cke), .req_valid(req_valid), .req_lead(req_lead),
      .req_len(req_len), .mrs_wr(mrs_wr), .mrs_ba(mrs_ba), .mrs_addr(mrs_addr), .odt(odt),
      .term_on(term_on), .rtt_code(rtt_code), .rtt_ohms(rtt_ohms), .sched_err(sched_err), .pd_err(pd_err));

   always #(PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // mode-register write; checks old value just before and new value at MOD
   task automatic emr(input logic [1:0] ba, input logic [13:0] addr, input int exp_code, input int old_code);
      @(negedge clk); mrs_wr = 1'b1; mrs_ba = ba; mrs_addr = addr;
      @(negedge clk); mrs_wr = 1'b0;
      idle(MOD - 1);
      chk("R2 strength not yet applied", rtt_code, old_code);
      @(negedge clk);
      chk("R2 strength applied after delay", rtt_code, exp_code);
   endtask

   task automatic run_req(input int lead, input int len, input int ok, input int rtt_on, input string tag);
      @(negedge clk); cke = 1'b1; req_valid = 1'b1; req_lead = 6'(lead); req_len = 4'(len);
      for (int m = 0; m <= lead + len + 3; m++) begin
         @(negedge clk);
         if (m == 0) begin
            chk({tag, " R7 refusal flag"}, sched_err, ok ? 0 : 1);
            req_valid = 1'b0;
         end
         chk({tag, " R4 odt"}, odt, (ok != 0 && m >= lead - AOND && m <= lead - AOND + len - 1) ? 1 : 0);
         chk({tag, " R5 R6 term_on"}, term_on, (ok != 0 && rtt_on != 0 && m >= lead && m <= lead + len) ? 1 : 0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      chk("R10 odt in reset", odt, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 term_on after reset", term_on, 0);
      chk("R10 strength after reset", rtt_code, 0);
      chk("R10 errors after reset", {30'd0, sched_err, pd_err}, 0);

      // R1 decode of every code, with unrelated address bits set
      emr(2'd1, 14'h0004, 1, 0);  chk("R1 75 ohm", rtt_ohms, 75);
      emr(2'd1, 14'h0040, 2, 1);  chk("R1 150 ohm", rtt_ohms, 150);
      emr(2'd1, 14'h3FBB, 0, 2);  chk("R1 off", rtt_ohms, 0);
      emr(2'd1, 14'h0044, 3, 0);  chk("R1 50 ohm", rtt_ohms, 50);
      // R2 other bank field ignored
      @(negedge clk); mrs_wr = 1'b1; mrs_ba = 2'd0; mrs_addr = 14'h0004;
      @(negedge clk); mrs_wr = 1'b0;
      idle(MOD + 2);
      chk("R2 other bank ignored", rtt_code, 3);

      idle(10);
      foreach (VEC[i]) begin
         run_req(VEC[i][0], VEC[i][1], VEC[i][2], 1, "table");
         idle(2);
      end

      // R7 busy refusal: second request while first is pending
      @(negedge clk); req_valid = 1'b1; req_lead = 6'd6; req_len = 4'd2;
      @(negedge clk); req_lead = 6'd2; req_len = 4'd1;
      @(negedge clk); req_valid = 1'b0;
      chk("R7 busy refused", sched_err, 1);
      chk("R7 odt untouched by refused request", odt, 0);
      idle(3);
      chk("R4 first burst still runs", odt, 1);
      idle(8);

      // R3 disabled strength
      emr(2'd1, 14'h0000, 0, 3);
      run_req(3, 2, 1, 0, "disabled R3");
      emr(2'd1, 14'h0044, 3, 0);

      // R8 request while powered down
      @(negedge clk); cke = 1'b0;
      @(negedge clk); req_valid = 1'b1; req_lead = 6'd20; req_len = 4'd1;
      @(negedge clk); req_valid = 1'b0;
      chk("R8 refused while down", sched_err, 1);
      // R8 request on exit edge, rise 7 cycles after exit
      run_req(9, 1, 0, 1, "exit R8 short");
      @(negedge clk); cke = 1'b0;
      idle(3);
      run_req(10, 1, 1, 1, "exit R8 exact");
      idle(10);

      // R9 entry with a burst scheduled
      @(negedge clk); req_valid = 1'b1; req_lead = 6'd10; req_len = 4'd2;
      @(negedge clk); req_valid = 1'b0; cke = 1'b0;
      @(negedge clk); chk("R9 entry while scheduled", pd_err, 1);
      cke = 1'b1;
      idle(20);
      // R9 entry two edges after the pin fell
      @(negedge clk); req_valid = 1'b1; req_lead = 6'd2; req_len = 4'd1;
      @(negedge clk); req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk); cke = 1'b0;
      @(negedge clk); chk("R9 entry too close", pd_err, 1);
      cke = 1'b1;
      idle(20);
      // R9 entry three edges after the pin fell
      @(negedge clk); req_valid = 1'b1; req_lead = 6'd2; req_len = 4'd1;
      @(negedge clk); req_valid = 1'b0;
      idle(2);
      @(negedge clk); cke = 1'b0;
      @(negedge clk); chk("R9 entry far enough", pd_err, 0);
      cke = 1'b1;
      idle(AXPD + 2);
      run_req(4, 3, 1, 1, "after exit");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule